// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the time of day for a precision-time Ethernet MAC. The time is held as a 48-bit seconds count and a nanoseconds count that runs from 0 to 999,999,999. On every clock cycle the nanoseconds advance by a programmed whole-nanosecond step. A 24-bit fraction accumulator runs beside it, and its carry adds one more nanosecond on the cycles where it overflows. Through this fraction a clock whose period is not a whole number of nanoseconds still yields the correct average rate.

Software uses a small register port: one write strobe, a word address, write data and a combinational read bus. It can load the nanoseconds or the seconds, program the rate and nudge the time by a signed offset. A seconds load is done in two steps. The upper 16 bits are staged first, and the load happens on the write of the lower 32 bits. A new rate is also done in two steps. The fraction is staged first, and both parts take effect on the write of the whole-nanosecond step. The offset register applies its shift once, in the same cycle as the normal advance. Reads return the live count, so software that needs a consistent time reads the nanoseconds twice around the seconds.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, the nanoseconds, the seconds, the staged and active increments and the fraction accumulator are all zero. While the whole-nanosecond step is zero, the active fraction is zero and no offset is written, the time stays unchanged.
- R2: Each cycle without a nanoseconds load, the nanoseconds advance by the active whole-nanosecond step, plus one when the 24-bit fraction accumulator overflows on adding the active fraction.
- R3: When the nanoseconds reach 1,000,000,000 or more, they drop by 1,000,000,000 and the seconds count rises by one. The seconds count wraps modulo 2^48.
- R4: A write to address 3 only stages a 24-bit fraction. Data bits [15:0] give fraction bits [23:8], and data bits [31:24] give fraction bits [7:0]. A write to address 4 makes data bits [7:0] the active whole-nanosecond step and makes the staged fraction active. The new values govern the cycles after that write.
- R5: A write to address 2 stages seconds bits [47:32] and leaves the running time alone. A write to address 1 loads the seconds with {staged high bits, write data}. The nanoseconds still advance in that cycle, and any rollover carry from that cycle is dropped.
- R6: A write to address 0 loads the nanoseconds from data bits [29:0], with no advance in that cycle and the seconds unchanged. A value of 1,000,000,000 or more loads zero.
- R7: A write to address 5 shifts the time once. Data bit 31 selects subtraction when it is 1, and data bits [29:0] give the magnitude in nanoseconds. The shift is added to the same cycle's advance. The result is brought back into range with up to two seconds of carry or borrow.
- R8: Reads return the following values:
  - address 0: the live nanoseconds
  - address 1: seconds [31:0]
  - address 2: seconds [47:32] in bits [15:0]
  - address 3: the staged fraction, in the packing of R4
  - address 4: the active whole-nanosecond step
  - any other address: zero

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The cycle that needs the closest look is the one where an offset write falls on the same edge as the ordinary advance, and that edge also crosses the second boundary. The bench sets the nanoseconds to 999,999,996 with a step of 8 and then writes an offset of +10. It expects nanoseconds 14 and the seconds up by one, not two separate updates. The mirror case subtracts more than the current nanoseconds plus the step, and the bench expects a borrow down to 999,999,992 with one second removed. The same two actions are also mixed into a stimulus table and compared against a cycle model of the requirements.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int NS_W         = 30;
    localparam int SEC_W        = 48;
    localparam int SEC_LO_W     = DATA_W;
    localparam int SEC_HI_W     = SEC_W - SEC_LO_W;
    localparam int FRAC_W       = 24;
    localparam int FRAC_LO_W    = 8;
    localparam int FRAC_HI_W    = FRAC_W - FRAC_LO_W;
    localparam int INC_W        = 8;
    localparam int STEP_W       = INC_W + 1;
    localparam int ADJ_W        = 30;
    localparam int ADJ_SIGN_BIT = DATA_W - 1;
    localparam longint NS_PER_SEC = 64'd1000000000;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_NS       = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEC_LO   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEC_HI   = 3'd2;
    localparam logic [ADDR_W-1:0] A_INC_FRAC = 3'd3;
    localparam logic [ADDR_W-1:0] A_INC_NS   = 3'd4;
    localparam logic [ADDR_W-1:0] A_ADJ      = 3'd5;

    typedef struct packed {
        logic [NS_W-1:0]     ns;
        logic [SEC_W-1:0]    sec;
        logic [SEC_HI_W-1:0] sec_hi_stage;
        logic [FRAC_W-1:0]   frac_stage;
        logic [FRAC_W-1:0]   inc_frac;
        logic [INC_W-1:0]    inc_ns;
        logic [FRAC_W-1:0]   acc;
    } tod_state_t;

endpackage

// File: rtl/ptp_frac_accum.sv
// Fractional-nanosecond accumulator: returns next accumulator value and
// the whole-nanosecond step for this cycle (increment plus carry).
module ptp_frac_accum #(
    parameter int FRAC_W = 24,
    parameter int INC_W  = 8,
    localparam int STEP_W = INC_W + 1
) (
    input  logic [FRAC_W-1:0] acc,
    input  logic [FRAC_W-1:0] inc_frac,
    input  logic [INC_W-1:0]  inc_ns,
    output logic [FRAC_W-1:0] acc_next,
    output logic [STEP_W-1:0] step
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum      = {1'b0, acc} + {1'b0, inc_frac};
        acc_next = sum[FRAC_W-1:0];
        step     = {1'b0, inc_ns} + {{(STEP_W-1){1'b0}}, sum[FRAC_W]};
    end
endmodule

// File: rtl/ptp_ns_normalize.sv
// Adds the tick step and an optional signed offset to the nanoseconds and
// folds the result back into [0, NS_PER_SEC) with a -2..+2 seconds delta.
module ptp_ns_normalize #(
    parameter int     NS_W       = 30,
    parameter int     STEP_W     = 9,
    parameter int     ADJ_W      = 30,
    parameter longint NS_PER_SEC = 64'd1000000000,
    localparam int    SUM_W      = NS_W + 3
) (
    input  logic [NS_W-1:0]   ns,
    input  logic [STEP_W-1:0] step,
    input  logic              adj_en,
    input  logic              adj_sub,
    input  logic [ADJ_W-1:0]  adj_mag,
    output logic [NS_W-1:0]   ns_out,
    output logic signed [2:0] sec_delta
);
    localparam logic signed [SUM_W-1:0] ONE_SEC = SUM_W'(NS_PER_SEC);
    localparam logic signed [SUM_W-1:0] TWO_SEC = SUM_W'(2 * NS_PER_SEC);

    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] mag;
    logic signed [SUM_W-1:0] total;
    logic signed [SUM_W-1:0] fixed;
    logic [SUM_W-NS_W-1:0]   unused_hi;

    always_comb begin
        base  = $signed({{(SUM_W-NS_W){1'b0}}, ns})
              + $signed({{(SUM_W-STEP_W){1'b0}}, step});
        mag   = adj_en ? $signed({{(SUM_W-ADJ_W){1'b0}}, adj_mag}) : '0;
        total = adj_sub ? (base - mag) : (base + mag);

        if (total < -ONE_SEC) begin
            fixed     = total + TWO_SEC;
            sec_delta = -3'sd2;
        end else if (total[SUM_W-1]) begin
            fixed     = total + ONE_SEC;
            sec_delta = -3'sd1;
        end else if (total >= TWO_SEC) begin
            fixed     = total - TWO_SEC;
            sec_delta = 3'sd2;
        end else if (total >= ONE_SEC) begin
            fixed     = total - ONE_SEC;
            sec_delta = 3'sd1;
        end else begin
            fixed     = total;
            sec_delta = 3'sd0;
        end
        ns_out    = fixed[NS_W-1:0];
        unused_hi = fixed[SUM_W-1:NS_W];
    end
endmodule

// File: rtl/ptp_bus_read.sv
// Combinational read multiplexer of the register port.
module ptp_bus_read
    import ptp_tod_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NS_W-1:0]   ns,
    input  logic [SEC_W-1:0]  sec,
    input  logic [FRAC_W-1:0] frac_stage,
    input  logic [INC_W-1:0]  inc_ns,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (addr)
            A_NS:       rdata = {{(DATA_W-NS_W){1'b0}}, ns};
            A_SEC_LO:   rdata = sec[SEC_LO_W-1:0];
            A_SEC_HI:   rdata = {{(DATA_W-SEC_HI_W){1'b0}}, sec[SEC_W-1:SEC_LO_W]};
            A_INC_FRAC: rdata = {frac_stage[FRAC_LO_W-1:0],
                                 {(DATA_W-FRAC_W){1'b0}},
                                 frac_stage[FRAC_W-1:FRAC_LO_W]};
            A_INC_NS:   rdata = {{(DATA_W-INC_W){1'b0}}, inc_ns};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptp_tod_counter.sv
// Time-of-day counter: two-process state update around the accumulator,
// the normalizer and the read multiplexer.
module ptp_tod_counter
    import ptp_tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_PER_SEC);

    tod_state_t cur_q;
    tod_state_t nxt_d;

    logic [FRAC_W-1:0] acc_next;
    logic [STEP_W-1:0] step;
    logic              adj_hit;
    logic [NS_W-1:0]   norm_ns;
    logic signed [2:0] sec_delta;

    // Flat views of the state, used by the bound checker
    logic [NS_W-1:0]   ns_q;
    logic [SEC_W-1:0]  sec_q;
    logic [INC_W-1:0]  inc_ns_q;
    logic [FRAC_W-1:0] inc_frac_q;
    logic [FRAC_W-1:0] frac_stage_q;

    assign ns_q         = cur_q.ns;
    assign sec_q        = cur_q.sec;
    assign inc_ns_q     = cur_q.inc_ns;
    assign inc_frac_q   = cur_q.inc_frac;
    assign frac_stage_q = cur_q.frac_stage;

    assign adj_hit = bus_we && (bus_addr == A_ADJ);

    ptp_frac_accum #(
        .FRAC_W (FRAC_W),
        .INC_W  (INC_W)
    ) u_accum (
        .acc      (cur_q.acc),
        .inc_frac (cur_q.inc_frac),
        .inc_ns   (cur_q.inc_ns),
        .acc_next (acc_next),
        .step     (step)
    );

    ptp_ns_normalize #(
        .NS_W       (NS_W),
        .STEP_W     (STEP_W),
        .ADJ_W      (ADJ_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_norm (
        .ns        (cur_q.ns),
        .step      (step),
        .adj_en    (adj_hit),
        .adj_sub   (bus_wdata[ADJ_SIGN_BIT]),
        .adj_mag   (bus_wdata[ADJ_W-1:0]),
        .ns_out    (norm_ns),
        .sec_delta (sec_delta)
    );

    ptp_bus_read u_read (
        .addr       (bus_addr),
        .ns         (cur_q.ns),
        .sec        (cur_q.sec),
        .frac_stage (cur_q.frac_stage),
        .inc_ns     (cur_q.inc_ns),
        .rdata      (bus_rdata)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.acc = acc_next;
        nxt_d.ns  = norm_ns;
        nxt_d.sec = cur_q.sec + {{(SEC_W-3){sec_delta[2]}}, sec_delta};

        if (bus_we) begin
            unique case (bus_addr)
                A_NS: begin
                    nxt_d.ns  = (bus_wdata[NS_W-1:0] < NS_LIMIT) ? bus_wdata[NS_W-1:0] : '0;
                    nxt_d.sec = cur_q.sec;
                end
                A_SEC_LO:   nxt_d.sec = {cur_q.sec_hi_stage, bus_wdata[SEC_LO_W-1:0]};
                A_SEC_HI:   nxt_d.sec_hi_stage = bus_wdata[SEC_HI_W-1:0];
                A_INC_FRAC: nxt_d.frac_stage = {bus_wdata[FRAC_HI_W-1:0],
                                                bus_wdata[DATA_W-1 -: FRAC_LO_W]};
                A_INC_NS: begin
                    nxt_d.inc_ns   = bus_wdata[INC_W-1:0];
                    nxt_d.inc_frac = cur_q.frac_stage;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/ptp_tod_counter_checker.sv
module ptp_tod_counter_checker
    import ptp_tod_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NS_W-1:0]   ns_q,
    input logic [SEC_W-1:0]  sec_q,
    input logic [INC_W-1:0]  inc_ns_q,
    input logic [FRAC_W-1:0] inc_frac_q,
    input logic [FRAC_W-1:0] frac_stage_q
);
    localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_PER_SEC);
    localparam logic [NS_W-1:0] NS_SAFE  = NS_W'(NS_PER_SEC - 512);

    // R3: nanoseconds always inside one second
    assert_ns_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ns_q < NS_LIMIT);

    // R1: zero rate without writes freezes the time
    assert_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && inc_ns_q == '0 && inc_frac_q == '0) |=> ($stable(ns_q) && $stable(sec_q)));

    // R2: plain tick moves by step or step plus one
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && ns_q < NS_SAFE) |=>
        ((32'(ns_q) - 32'($past(ns_q)) == 32'($past(inc_ns_q))) ||
         (32'(ns_q) - 32'($past(ns_q)) == 32'($past(inc_ns_q)) + 32'd1)));

    // R4: staging a fraction does not touch the active one
    assert_frac_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_INC_FRAC) |=> $stable(inc_frac_q));

    // R4: the commit write activates step and staged fraction
    assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_INC_NS) |=>
        (inc_ns_q == $past(bus_wdata[INC_W-1:0]) && inc_frac_q == $past(frac_stage_q)));

    // R5: staging high seconds leaves the seconds alone apart from rollover
    assert_hi_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SEC_HI) |=>
        (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 48'd1));

    // R5: low seconds write loads the low word
    assert_sec_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SEC_LO) |=> (sec_q[SEC_LO_W-1:0] == $past(bus_wdata)));

    // R6: in-range nanoseconds write loads directly
    assert_ns_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_NS && bus_wdata[NS_W-1:0] < NS_LIMIT) |=>
        (ns_q == $past(bus_wdata[NS_W-1:0]) && $stable(sec_q)));
endmodule

bind ptp_tod_counter ptp_tod_counter_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .ns_q         (ns_q),
    .sec_q        (sec_q),
    .inc_ns_q     (inc_ns_q),
    .inc_frac_q   (inc_frac_q),
    .frac_stage_q (frac_stage_q)
);

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ptp_tod_counter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Reference model of the requirements
    localparam longint ONE_SEC  = 64'd1000000000;
    localparam longint SEC_MASK = 64'h0000_FFFF_FFFF_FFFF;
    longint      m_ns = 0;
    longint      m_sec = 0;
    longint      m_inc = 0;
    logic [23:0] m_acc = 24'd0;
    logic [23:0] m_frac = 24'd0;
    logic [23:0] m_stage = 24'd0;
    logic [15:0] m_hi = 16'd0;

    task automatic model_tick(input logic we, input logic [2:0] a, input logic [31:0] d);
        longint sum;
        longint t;
        longint step;
        sum   = longint'(m_acc) + longint'(m_frac);
        step  = m_inc + (sum >> 24);
        m_acc = sum[23:0];
        if (we && a == 3'd0) begin
            m_ns = (longint'(d[29:0]) < ONE_SEC) ? longint'(d[29:0]) : 0;
        end else if (we && a == 3'd1) begin
            t = m_ns + step;
            if (t >= ONE_SEC) t = t - ONE_SEC;
            m_ns  = t;
            m_sec = {16'd0, m_hi, d};
        end else begin
            t = m_ns + step;
            if (we && a == 3'd5) t = d[31] ? t - longint'(d[29:0]) : t + longint'(d[29:0]);
            while (t < 0) begin t = t + ONE_SEC; m_sec = m_sec - 1; end
            while (t >= ONE_SEC) begin t = t - ONE_SEC; m_sec = m_sec + 1; end
            m_sec = m_sec & SEC_MASK;
            m_ns  = t;
        end
        if (we && a == 3'd2) m_hi = d[15:0];
        if (we && a == 3'd3) m_stage = {d[15:0], d[31:24]};
        if (we && a == 3'd4) begin m_inc = longint'(d[7:0]); m_frac = m_stage; end
    endtask

    task automatic do_cycle(input logic we, input logic [2:0] a, input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_tick(we, a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_cycle(1'b0, 3'd0, 32'd0);
    endtask

    task automatic check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %0d actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic check_model(input string tag);
        check(3'd0, m_ns[31:0], tag);
        check(3'd1, m_sec[31:0], tag);
        check(3'd2, {16'd0, m_sec[47:32]}, tag);
    endtask

    typedef struct packed {
        logic [2:0]  a;
        logic [31:0] d;
        logic [7:0]  wait_n;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{3'd2, 32'h0000_0001, 8'd0},
        '{3'd1, 32'h0000_0005, 8'd2},
        '{3'd0, 32'd999999990, 8'd0},
        '{3'd3, 32'h0000_8000, 8'd0},
        '{3'd4, 32'd8,         8'd5},
        '{3'd5, 32'd100,       8'd3},
        '{3'd5, 32'h8000_01F4, 8'd3},
        '{3'd3, 32'h5600_1234, 8'd4},
        '{3'd4, 32'd2,         8'd6},
        '{3'd0, 32'd1000,      8'd10},
        '{3'd5, 32'h8000_1388, 8'd2},
        '{3'd4, 32'd40,        8'd30}
    };

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: reset values on every address
        for (int a = 0; a < 8; a++) check(3'(a), 32'd0, "R1 reset R8");
        idle(5);
        check(3'd0, 32'd0, "R1 stopped");
        check(3'd1, 32'd0, "R1 stopped");

        // R4: a staged fraction has no effect before commit
        do_cycle(1'b1, 3'd3, 32'h0000_C000);
        idle(20);
        check(3'd0, 32'd0, "R4 pending fraction");
        check(3'd3, 32'h0000_C000, "R4 staged readback");
        check(3'd4, 32'd0, "R4 step not committed");

        // Table walk against the model (R2 R3 R5 R7 R8)
        for (int i = 0; i < 12; i++) begin
            do_cycle(1'b1, VECS[i].a, VECS[i].d);
            idle(int'(VECS[i].wait_n));
            check_model("R2 table");
        end
        check(3'd3, 32'h5600_1234, "R8 fraction packing");
        check(3'd4, 32'd40, "R8 step readback");

        // R6: nanoseconds load
        do_cycle(1'b1, 3'd0, 32'd1000000000);
        check(3'd0, 32'd0, "R6 out of range");
        do_cycle(1'b1, 3'd0, 32'd123);
        check(3'd0, 32'd123, "R6 direct load");

        // R7 with R3: offset and rollover in one cycle
        do_cycle(1'b1, 3'd3, 32'h0000_0000);
        do_cycle(1'b1, 3'd4, 32'd8);
        do_cycle(1'b1, 3'd2, 32'd0);
        do_cycle(1'b1, 3'd1, 32'd7);
        do_cycle(1'b1, 3'd0, 32'd999999996);
        do_cycle(1'b1, 3'd5, 32'd10);
        check(3'd0, 32'd14, "R7 add with rollover");
        check(3'd1, 32'd8, "R7 add with rollover");
        do_cycle(1'b1, 3'd5, 32'h8000_001E);
        check(3'd0, 32'd999999992, "R7 subtract borrow");
        check(3'd1, 32'd7, "R7 subtract borrow");

        // R3: plain rollover
        do_cycle(1'b1, 3'd0, 32'd999999995);
        idle(1);
        check(3'd0, 32'd3, "R3 rollover");
        check(3'd1, 32'd8, "R3 rollover");

        // R5: high seconds staged only
        do_cycle(1'b1, 3'd2, 32'h0000_00AB);
        check(3'd2, 32'd0, "R5 high staged");
        check(3'd1, 32'd8, "R5 high staged");
        check(3'd0, 32'd11, "R5 ns keeps running");
        do_cycle(1'b1, 3'd1, 32'd2);
        check(3'd2, 32'h0000_00AB, "R5 load on low write");
        check(3'd1, 32'd2, "R5 load on low write");

        // R3: 48-bit seconds wrap
        do_cycle(1'b1, 3'd2, 32'h0000_FFFF);
        do_cycle(1'b1, 3'd1, 32'hFFFF_FFFF);
        do_cycle(1'b1, 3'd0, 32'd999999999);
        idle(1);
        check(3'd0, 32'd7, "R3 seconds wrap");
        check(3'd1, 32'd0, "R3 seconds wrap");
        check(3'd2, 32'd0, "R3 seconds wrap");

        // R2: quarter-nanosecond fraction gives two carries in eight ticks
        do_cycle(1'b1, 3'd3, 32'h0000_4000);
        do_cycle(1'b1, 3'd4, 32'd0);
        do_cycle(1'b1, 3'd0, 32'd0);
        idle(8);
        check(3'd0, 32'd2, "R2 fraction carry");
        do_cycle(1'b1, 3'd4, 32'd3);
        idle(10);
        check_model("R2 step plus fraction");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule